// File: doc/BRIEF.md
# Disk command sequencer

This block is the command engine of a memory-mapped controller for moving-head disk drives. Each drive carries two platters, one removable and one fixed. Software writes single bytes into a small register window. The window holds a unit number, a two-byte target address (cylinder, head and sector), a per-platter write-enable mask, a command byte and several strobes that control the interrupt. A state machine then performs a seek, a return to track zero, or a multi-sector read or write. It drives an interrupt line when the command is over.

The drives are reached through plain handshake lines:
- a per-drive ready, on-cylinder, address-acknowledge, fault, write-protect and seek-error input;
- a sector pulse with its sector number from the selected drive.

The serial data path is outside this block and reports to it only through these events: sync found, format error, header good, header bad, and sector finished with a CRC verdict. A DMA engine receives a request line and a direction, and it returns a done pulse that ends a transfer.

A 16-bit status word is captured from live conditions only when the state machine moves between states or when a unit is selected. Software reads it as two bytes.

Top module: `dskc_ctrl`

## Requirements
- R1: After reset the status bytes read 0x00, the command register reads 0, `irq` is 0 and `dma_req` is 0.
- R2: The target cylinder is 9 bits. Offset 1 holds its bits 8..3 in data bits 5..0 and reads back with bits 7..6 zero. A write to offset 2 sets cylinder bits 2..0 from data bits 7..5, the head from bit 4 and the sector from bits 3..0. Reading offset 2 returns the latched cylinder low bits and head with the drive's live `drv_sec_num` in bits 3..0. `drv_cyl`, `drv_head` and `drv_sector` present the target.
- R3: A command byte written to offset 4 while idle starts a command: 0 read, 1 write, 2 seek, 3 return-to-zero. Any other value is ignored. Any command written while the block is not idle is ignored.
- R4: The unit number written to offset 0 selects drive = unit/2 (`drv_sel`) and platter = unit bit 0. A seek asserts `drv_seek_req` only when that drive is ready. A return-to-zero asserts `drv_rtz_req` regardless of ready. When the drive acknowledges, its seek-active flag is set and its seek-complete flag is cleared. On-cylinder from that drive then clears active and sets complete. The command finishes once no drive is seek-active. Seek-complete flags appear in status bits 3..0, one bit per drive.
- R5: A read or write waits for a sector pulse whose number equals the target sector. It then needs a sync, a good header and a second sync. `dma_req` is raised when the good header arrives, with `dma_rd` = 1 for read and 0 for write. A finished sector with good CRC advances the target sector modulo 16 and waits for the next sector. `dma_done` ends the command.
- R6: A format error during either sync wait ends the command and sets status bit 12. A bad header sets bit 13. A bad CRC sets bit 11. Starting a command clears all four error flags, and so does a write to offset 5 or 6.
- R7: A command still running `TIMEOUT_CYC` cycles after it started sets status bit 14, drops `dma_req` and is forced to finish.
- R8: A fault from the selected drive while a command runs ends the command at once. Status bit 9 mirrors that drive's fault. Bits 4, 5, 7 and 10 mirror its ready, on-cylinder, write-protect and seek-error lines, and bit 8 is busy.
- R9: The status word is captured in the cycle after a state change or a unit-select write and holds otherwise. High byte at offset 5, low byte at offset 6.
- R10: Strobe writes to offset 8 force the finish state, offset 9 disables interrupts, offset 10 enables them and offset 11 acknowledges. In finish with interrupts enabled, `irq` rises and the block stays busy until the acknowledge, which drops `irq` and returns to idle. With interrupts disabled, finish lasts one cycle.
- R11: `drv_wr_gate` is high only while a write transfer holds `dma_req` and the mask bit indexed by the unit number (offset 3) is set.
- R12: Offset 4 reads back bit 0 = 1 whenever the state machine is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| drv_ready | input | NUM_DRIVES | Per-drive ready |
| drv_on_cyl | input | NUM_DRIVES | Per-drive on-cylinder |
| drv_addr_ack | input | NUM_DRIVES | Per-drive address acknowledge |
| drv_fault | input | NUM_DRIVES | Per-drive fault |
| drv_wprot | input | NUM_DRIVES | Per-drive write protect |
| drv_seek_err | input | NUM_DRIVES | Per-drive seek error |
| drv_sec_pulse | input | 1 | Sector pulse of the selected drive |
| drv_sec_num | input | 4 | Sector number under the head |
| drv_sel | output | log2(NUM_DRIVES) | Selected drive |
| drv_platter | output | 1 | 0 removable, 1 fixed |
| drv_cyl | output | 9 | Target cylinder |
| drv_head | output | 1 | Target head |
| drv_sector | output | 4 | Target sector |
| drv_seek_req | output | 1 | Seek request |
| drv_rtz_req | output | 1 | Return-to-zero request |
| drv_wr_gate | output | 1 | Write allowed to the selected platter |
| ser_sync | input | 1 | Sync pattern found |
| ser_fmt_err | input | 1 | Sync pattern missing |
| ser_hdr_ok | input | 1 | Header matched |
| ser_hdr_bad | input | 1 | Header mismatch |
| ser_sec_done | input | 1 | Sector data finished |
| ser_crc_bad | input | 1 | CRC verdict with `ser_sec_done` |
| dma_req | output | 1 | DMA request |
| dma_rd | output | 1 | 1 disk to memory, 0 memory to disk |
| dma_done | input | 1 | DMA count exhausted |
| irq | output | 1 | Interrupt request |

## Verification
Because the status word is latched, a wrong state shows at the ports in two ways. Bit 0 of the command register changes at once. The status bytes change one cycle after the move, or they fail to change. A stuck seek-active flag keeps the block busy until the timeout, and that later shows as status bit 14. A miscounted target sector shows immediately on `drv_sector`, and a missed header or sync keeps `dma_req` low. Wrong interrupt handling shows within one strobe as an `irq` level that does not match the acknowledge, or as a busy bit that clears too early.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

    // register offsets inside the window
    localparam logic [3:0] OFS_UNIT   = 4'h0;
    localparam logic [3:0] OFS_CYLHI  = 4'h1;
    localparam logic [3:0] OFS_ADDRLO = 4'h2;
    localparam logic [3:0] OFS_WMASK  = 4'h3;
    localparam logic [3:0] OFS_CMD    = 4'h4;
    localparam logic [3:0] OFS_STHI   = 4'h5;
    localparam logic [3:0] OFS_STLO   = 4'h6;
    localparam logic [3:0] OFS_FORCE  = 4'h8;
    localparam logic [3:0] OFS_IRQOFF = 4'h9;
    localparam logic [3:0] OFS_IRQON  = 4'hA;
    localparam logic [3:0] OFS_ACK    = 4'hB;

    localparam logic [7:0] CMD_READ  = 8'd0;
    localparam logic [7:0] CMD_WRITE = 8'd1;
    localparam logic [7:0] CMD_SEEK  = 8'd2;
    localparam logic [7:0] CMD_RTZ   = 8'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEEK,
        ST_RTZ,
        ST_WSEEK,
        ST_WSEC,
        ST_ASYNC,
        ST_HDR,
        ST_DSYNC,
        ST_XFER,
        ST_FINISH
    } st_e;

    typedef struct packed {
        logic       rsv15;
        logic       tmo;
        logic       adr_err;
        logic       fmt_err;
        logic       crc_err;
        logic       seek_err;
        logic       fault;
        logic       busy;
        logic       wprot;
        logic       wr_en;
        logic       on_cyl;
        logic       ready;
        logic [3:0] seek_cmp;
    } stat_t;

    function automatic logic is_work(st_e s);
        return (s != ST_IDLE) && (s != ST_FINISH);
    endfunction

    function automatic logic is_cmd(logic [7:0] c);
        return c <= CMD_RTZ;
    endfunction

endpackage

// File: rtl/dskc_regs.sv
module dskc_regs #(
    parameter int UW = 3,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [7:0]    wdata,
    input  logic          sec_inc,
    output logic [UW-1:0] unit_q,
    output logic [8:0]    cyl_q,
    output logic          head_q,
    output logic [3:0]    sec_q,
    output logic [MW-1:0] wmask_q,
    output logic          irq_en_q,
    output logic          cmd_wr,
    output logic          sel_wr,
    output logic          clr_wr,
    output logic          force_wr,
    output logic          ack_wr
);
    import dskc_pkg::*;

    always_comb begin
        cmd_wr   = we && (addr == OFS_CMD);
        sel_wr   = we && (addr == OFS_UNIT);
        clr_wr   = we && ((addr == OFS_STHI) || (addr == OFS_STLO));
        force_wr = we && (addr == OFS_FORCE);
        ack_wr   = we && (addr == OFS_ACK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_q   <= '0;
            cyl_q    <= '0;
            head_q   <= 1'b0;
            sec_q    <= '0;
            wmask_q  <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (sel_wr) unit_q <= wdata[UW-1:0];
            if (we && addr == OFS_CYLHI) cyl_q[8:3] <= wdata[5:0];
            if (we && addr == OFS_ADDRLO) begin
                cyl_q[2:0] <= wdata[7:5];
                head_q     <= wdata[4];
                sec_q      <= wdata[3:0];
            end else if (sec_inc) begin
                sec_q <= sec_q + 4'd1;
            end
            if (we && addr == OFS_WMASK) wmask_q <= wdata[MW-1:0];
            if (we && addr == OFS_IRQOFF) irq_en_q <= 1'b0;
            else if (we && addr == OFS_IRQON) irq_en_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dskc_seek_trk.sv
module dskc_seek_trk #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] mark,
    input  logic [N-1:0] on_cyl,
    output logic [N-1:0] act,
    output logic [N-1:0] cmp
);
    for (genvar i = 0; i < N; i++) begin : g_drv
        always_ff @(posedge clk) begin
            if (rst) begin
                act[i] <= 1'b0;
                cmp[i] <= 1'b0;
            end else if (mark[i]) begin
                act[i] <= 1'b1;
                cmp[i] <= 1'b0;
            end else if (act[i] && on_cyl[i]) begin
                act[i] <= 1'b0;
                cmp[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dskc_tmo.sv
module dskc_tmo #(
    parameter int LIMIT = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic disarm,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic          armed;
    logic [CW-1:0] cnt;

    assign expire = armed && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (disarm) begin
            armed <= 1'b0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dskc_ctrl.sv
module dskc_ctrl #(
    parameter int NUM_DRIVES  = 4,
    parameter int TIMEOUT_CYC = 5_000_000,
    localparam int DRV_W = $clog2(NUM_DRIVES),
    localparam int UW    = DRV_W + 1,
    localparam int MW    = 2 * NUM_DRIVES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [3:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_DRIVES-1:0] drv_ready,
    input  logic [NUM_DRIVES-1:0] drv_on_cyl,
    input  logic [NUM_DRIVES-1:0] drv_addr_ack,
    input  logic [NUM_DRIVES-1:0] drv_fault,
    input  logic [NUM_DRIVES-1:0] drv_wprot,
    input  logic [NUM_DRIVES-1:0] drv_seek_err,
    input  logic                  drv_sec_pulse,
    input  logic [3:0]            drv_sec_num,
    output logic [DRV_W-1:0]      drv_sel,
    output logic                  drv_platter,
    output logic [8:0]            drv_cyl,
    output logic                  drv_head,
    output logic [3:0]            drv_sector,
    output logic                  drv_seek_req,
    output logic                  drv_rtz_req,
    output logic                  drv_wr_gate,
    input  logic                  ser_sync,
    input  logic                  ser_fmt_err,
    input  logic                  ser_hdr_ok,
    input  logic                  ser_hdr_bad,
    input  logic                  ser_sec_done,
    input  logic                  ser_crc_bad,
    output logic                  dma_req,
    output logic                  dma_rd,
    input  logic                  dma_done,
    output logic                  irq
);
    import dskc_pkg::*;

    logic [UW-1:0]         unit_q;
    logic [8:0]            cyl_q;
    logic                  head_q;
    logic [3:0]            sec_q;
    logic [MW-1:0]         wmask_q;
    logic                  irq_en_q;
    logic                  cmd_wr, sel_wr, clr_wr, force_wr, ack_wr;
    logic [NUM_DRIVES-1:0] seek_act, seek_cmp, mark_vec;
    logic                  expire;

    st_e   st_q, nxt;
    logic  mark, sinc, start;
    logic  set_fmt, set_adr, set_crc, set_tmo;
    logic  fmt_q, adr_q, crc_q, tmo_q;
    logic  dma_req_q, dma_rd_q, irq_q, upd_q;
    stat_t live;
    logic [15:0] status_q;
    logic [DRV_W-1:0] drv_idx;
    logic  ready_sel, ack_sel, fault_sel;

    dskc_regs #(.UW(UW), .MW(MW)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .sec_inc(sinc), .unit_q(unit_q), .cyl_q(cyl_q), .head_q(head_q),
        .sec_q(sec_q), .wmask_q(wmask_q), .irq_en_q(irq_en_q),
        .cmd_wr(cmd_wr), .sel_wr(sel_wr), .clr_wr(clr_wr),
        .force_wr(force_wr), .ack_wr(ack_wr)
    );

    dskc_seek_trk #(.N(NUM_DRIVES)) u_trk (
        .clk(clk), .rst(rst), .mark(mark_vec), .on_cyl(drv_on_cyl),
        .act(seek_act), .cmp(seek_cmp)
    );

    dskc_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst(rst), .arm(start), .disarm(nxt == ST_FINISH),
        .expire(expire)
    );

    assign drv_idx   = unit_q[DRV_W:1];
    assign ready_sel = drv_ready[drv_idx];
    assign ack_sel   = drv_addr_ack[drv_idx];
    assign fault_sel = drv_fault[drv_idx];

    assign drv_sel      = drv_idx;
    assign drv_platter  = unit_q[0];
    assign drv_cyl      = cyl_q;
    assign drv_head     = head_q;
    assign drv_sector   = sec_q;
    assign drv_seek_req = (st_q == ST_SEEK) && ready_sel;
    assign drv_rtz_req  = (st_q == ST_RTZ);
    assign drv_wr_gate  = dma_req_q && !dma_rd_q && wmask_q[unit_q];
    assign dma_req      = dma_req_q;
    assign dma_rd       = dma_rd_q;
    assign irq          = irq_q;

    always_comb begin
        mark_vec = '0;
        if (mark) mark_vec[drv_idx] = 1'b1;
    end

    // next-state logic
    always_comb begin
        nxt     = st_q;
        mark    = 1'b0;
        sinc    = 1'b0;
        start   = 1'b0;
        set_fmt = 1'b0;
        set_adr = 1'b0;
        set_crc = 1'b0;
        set_tmo = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cmd_wr && is_cmd(bus_wdata)) begin
                    start = 1'b1;
                    if (bus_wdata == CMD_SEEK)     nxt = ST_SEEK;
                    else if (bus_wdata == CMD_RTZ) nxt = ST_RTZ;
                    else                           nxt = ST_WSEC;
                end
            end
            ST_SEEK: begin
                if (drv_seek_req && ack_sel) begin
                    nxt  = ST_WSEEK;
                    mark = 1'b1;
                end
            end
            ST_RTZ: begin
                if (ack_sel) begin
                    nxt  = ST_WSEEK;
                    mark = 1'b1;
                end
            end
            ST_WSEEK: begin
                if (seek_act == '0) nxt = ST_FINISH;
            end
            ST_WSEC: begin
                if (drv_sec_pulse && drv_sec_num == sec_q) nxt = ST_ASYNC;
            end
            ST_ASYNC: begin
                if (ser_fmt_err) begin
                    set_fmt = 1'b1;
                    nxt     = ST_FINISH;
                end else if (ser_sync) begin
                    nxt = ST_HDR;
                end
            end
            ST_HDR: begin
                if (ser_hdr_bad) begin
                    set_adr = 1'b1;
                    nxt     = ST_FINISH;
                end else if (ser_hdr_ok) begin
                    nxt = ST_DSYNC;
                end
            end
            ST_DSYNC: begin
                if (ser_fmt_err) begin
                    set_fmt = 1'b1;
                    nxt     = ST_FINISH;
                end else if (ser_sync) begin
                    nxt = ST_XFER;
                end
            end
            ST_XFER: begin
                if (ser_sec_done) begin
                    if (ser_crc_bad) begin
                        set_crc = 1'b1;
                        nxt     = ST_FINISH;
                    end else begin
                        sinc = 1'b1;
                        nxt  = ST_WSEC;
                    end
                end
            end
            ST_FINISH: begin
                if (ack_wr)         nxt = ST_IDLE;
                else if (!irq_en_q) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        // aborts of a running command
        if (is_work(st_q) && (fault_sel || expire || (dma_done && dma_req_q))) begin
            nxt     = ST_FINISH;
            mark    = 1'b0;
            sinc    = 1'b0;
            set_tmo = expire;
        end
        if (force_wr) nxt = ST_FINISH;
    end

    // live status word, captured only on a state move or unit select
    always_comb begin
        live          = '0;
        live.seek_cmp = 4'(seek_cmp);
        live.ready    = ready_sel;
        live.on_cyl   = drv_on_cyl[drv_idx];
        live.wprot    = drv_wprot[drv_idx];
        live.busy     = (st_q != ST_IDLE);
        live.fault    = fault_sel;
        live.seek_err = drv_seek_err[drv_idx];
        live.crc_err  = crc_q;
        live.fmt_err  = fmt_q;
        live.adr_err  = adr_q;
        live.tmo      = tmo_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            fmt_q     <= 1'b0;
            adr_q     <= 1'b0;
            crc_q     <= 1'b0;
            tmo_q     <= 1'b0;
            dma_req_q <= 1'b0;
            dma_rd_q  <= 1'b0;
            irq_q     <= 1'b0;
            upd_q     <= 1'b0;
            status_q  <= '0;
        end else begin
            st_q  <= nxt;
            upd_q <= (nxt != st_q) || sel_wr;
            if (upd_q) status_q <= live;
            if (start || clr_wr) begin
                fmt_q <= 1'b0;
                adr_q <= 1'b0;
                crc_q <= 1'b0;
                tmo_q <= 1'b0;
            end else begin
                if (set_fmt) fmt_q <= 1'b1;
                if (set_adr) adr_q <= 1'b1;
                if (set_crc) crc_q <= 1'b1;
                if (set_tmo) tmo_q <= 1'b1;
            end
            if (start) dma_rd_q <= (bus_wdata == CMD_READ);
            if (nxt == ST_FINISH || nxt == ST_IDLE) dma_req_q <= 1'b0;
            else if (nxt == ST_DSYNC)                dma_req_q <= 1'b1;
            if (ack_wr) irq_q <= 1'b0;
            else if (st_q == ST_FINISH && irq_en_q) irq_q <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CYLHI:  bus_rdata = {2'b00, cyl_q[8:3]};
            OFS_ADDRLO: bus_rdata = {cyl_q[2:0], head_q, drv_sec_num};
            OFS_CMD:    bus_rdata = {7'd0, st_q != ST_IDLE};
            OFS_STHI:   bus_rdata = status_q[15:8];
            OFS_STLO:   bus_rdata = status_q[7:0];
            default:    bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/dskc_chk.sv
module dskc_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst,
    input dskc_pkg::st_e  st,
    input logic [15:0]    status_q,
    input logic           sel_wr,
    input logic [N-1:0]   seek_act,
    input logic [N-1:0]   seek_cmp,
    input logic           ack_wr,
    input logic           irq,
    input logic           expire,
    input logic           dma_req
);
    import dskc_pkg::*;

    // a drive is never both seeking and seek-complete
    assert_seek_excl_R4: assert property (@(posedge clk) disable iff (rst)
        (seek_act & seek_cmp) == '0);

    assert_irq_src_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(st) == ST_FINISH);

    assert_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> !irq);

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ($stable(st) && !$past(sel_wr)) |=> $stable(status_q));

    assert_tmo_fin_R7: assert property (@(posedge clk) disable iff (rst)
        expire |=> st == ST_FINISH);

    assert_dma_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !dma_req);

endmodule

bind dskc_ctrl dskc_chk #(.N(NUM_DRIVES)) u_chk (
    .clk(clk), .rst(rst), .st(st_q), .status_q(status_q), .sel_wr(sel_wr),
    .seek_act(seek_act), .seek_cmp(seek_cmp), .ack_wr(ack_wr), .irq(irq_q),
    .expire(expire), .dma_req(dma_req_q)
);

// File: tb/sim_dskc_ctrl.sv
module sim_dskc_ctrl;
    localparam int ND  = 4;
    localparam int TMO = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [ND-1:0] drv_ready = '0, drv_on_cyl = '0, drv_addr_ack = '0;
    logic [ND-1:0] drv_fault = '0, drv_wprot = '0, drv_seek_err = '0;
    logic drv_sec_pulse = 1'b0;
    logic [3:0] drv_sec_num = '0;
    logic [1:0] drv_sel;
    logic drv_platter, drv_head, drv_seek_req, drv_rtz_req, drv_wr_gate;
    logic [8:0] drv_cyl;
    logic [3:0] drv_sector;
    logic ser_sync = 0, ser_fmt_err = 0, ser_hdr_ok = 0, ser_hdr_bad = 0;
    logic ser_sec_done = 0, ser_crc_bad = 0, dma_done = 0;
    logic dma_req, dma_rd, irq;

    int total = 0;
    int bad = 0;
    logic [7:0] rv;

    // event masks for ser_pulse
    localparam logic [6:0] M_DONE = 7'h40, M_SYNC = 7'h20, M_FMT = 7'h10;
    localparam logic [6:0] M_HOK = 7'h08, M_HBAD = 7'h04, M_SEC = 7'h02, M_CRC = 7'h01;

    // {cylhi write, addrlo write, live sector, expected cylhi, expected addrlo}
    localparam logic [35:0] VECS [4] = '{
        {8'h2D, 8'hB5, 4'h7, 8'h2D, 8'hB7},
        {8'hFF, 8'h1F, 4'h0, 8'h3F, 8'h10},
        {8'h00, 8'hE0, 4'hA, 8'h00, 8'hEA},
        {8'h15, 8'h4C, 4'hC, 8'h15, 8'h4C}
    };

    dskc_ctrl #(.NUM_DRIVES(ND), .TIMEOUT_CYC(TMO)) u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ser_pulse(input logic [6:0] m);
        @(negedge clk);
        {dma_done, ser_sync, ser_fmt_err, ser_hdr_ok, ser_hdr_bad, ser_sec_done, ser_crc_bad} = m;
        @(negedge clk);
        {dma_done, ser_sync, ser_fmt_err, ser_hdr_ok, ser_hdr_bad, ser_sec_done, ser_crc_bad} = '0;
    endtask

    task automatic sec_pulse(input logic [3:0] n);
        @(negedge clk);
        drv_sec_pulse = 1'b1; drv_sec_num = n;
        @(negedge clk);
        drv_sec_pulse = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h5, rv); chk("R1 status hi", 16'(rv), 16'h00);
        rd(4'h6, rv); chk("R1 status lo", 16'(rv), 16'h00);
        rd(4'h4, rv); chk("R1 busy", 16'(rv), 16'h00);
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 dma_req", 16'(dma_req), 16'h0);

        // R2 address register layout, table walk
        for (int i = 0; i < 4; i++) begin
            wr(4'h1, VECS[i][35:28]);
            wr(4'h2, VECS[i][27:20]);
            drv_sec_num = VECS[i][19:16];
            rd(4'h1, rv); chk("R2 cyl hi", 16'(rv), 16'(VECS[i][15:8]));
            rd(4'h2, rv); chk("R2 addr lo", 16'(rv), 16'(VECS[i][7:0]));
            chk("R2 drv_cyl", 16'(drv_cyl), 16'({VECS[i][33:28], VECS[i][27:25]}));
            chk("R2 head/sector", 16'({drv_head, drv_sector}), 16'(VECS[i][24:20]));
        end

        // R4 seek on unit 2 = drive 1, platter 0
        drv_ready = 4'b0010;
        wr(4'h0, 8'd2);
        chk("R4 drv_sel", 16'({drv_sel, drv_platter}), 16'h2);
        wr(4'h4, 8'd2);
        chk("R4 seek_req", 16'(drv_seek_req), 16'h1);
        @(negedge clk); drv_addr_ack[1] = 1'b1;
        @(negedge clk); drv_addr_ack[1] = 1'b0;
        rd(4'h5, rv); chk("R4 busy during seek", 16'(rv), 16'h01);
        rd(4'h6, rv); chk("R4 seek-complete cleared", 16'(rv), 16'h10);
        @(negedge clk); drv_on_cyl[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd(4'h5, rv); chk("R4 done hi", 16'(rv), 16'h00);
        rd(4'h6, rv); chk("R4 done lo", 16'(rv), 16'h32);

        // R9 status holds while idle, re-captured on unit select
        drv_on_cyl[1] = 1'b0;
        repeat (3) @(negedge clk);
        rd(4'h6, rv); chk("R9 held", 16'(rv), 16'h32);
        wr(4'h0, 8'd2);
        rd(4'h6, rv); chk("R9 select recapture", 16'(rv), 16'h12);

        // R3 unknown code ignored
        wr(4'h4, 8'd5);
        rd(4'h4, rv); chk("R3 unknown code", 16'(rv), 16'h00);

        // R3 command while busy ignored; R7 timeout; R12 busy readback
        wr(4'h0, 8'd0);
        wr(4'h4, 8'd3);
        chk("R4 rtz_req", 16'(drv_rtz_req), 16'h1);
        wr(4'h4, 8'd2);
        chk("R3 busy ignores cmd", 16'({drv_rtz_req, drv_seek_req}), 16'h2);
        rd(4'h4, rv); chk("R12 busy bit", 16'(rv), 16'h01);
        repeat (30) @(negedge clk);
        rd(4'h4, rv); chk("R7 still busy before limit", 16'(rv), 16'h01);
        repeat (40) @(negedge clk);
        rd(4'h5, rv); chk("R7 timeout flag", 16'(rv), 16'h40);
        rd(4'h4, rv); chk("R12 idle after timeout", 16'(rv), 16'h00);

        // R6 clear by status write
        wr(4'h5, 8'h00);
        wr(4'h0, 8'd0);
        rd(4'h5, rv); chk("R6 clear by status write", 16'(rv), 16'h00);

        // R5 read with interrupt, R10
        drv_ready = 4'b0011;
        wr(4'h1, 8'h01);
        wr(4'h2, 8'h03);
        wr(4'hA, 8'h00);
        wr(4'h4, 8'd0);
        sec_pulse(4'h2);
        ser_pulse(M_SYNC);
        ser_pulse(M_HOK);
        chk("R5 wrong sector ignored", 16'(dma_req), 16'h0);
        sec_pulse(4'h3);
        ser_pulse(M_SYNC);
        ser_pulse(M_HOK);
        chk("R5 dma_req read", 16'({dma_req, dma_rd}), 16'h3);
        ser_pulse(M_SYNC);
        ser_pulse(M_SEC);
        chk("R5 sector advance", 16'(drv_sector), 16'h4);
        ser_pulse(M_DONE);
        repeat (2) @(negedge clk);
        chk("R10 irq held", 16'(irq), 16'h1);
        chk("R5 dma dropped", 16'(dma_req), 16'h0);
        rd(4'h4, rv); chk("R10 busy until ack", 16'(rv), 16'h01);
        wr(4'hB, 8'h00);
        chk("R10 irq after ack", 16'(irq), 16'h0);
        rd(4'h4, rv); chk("R10 idle after ack", 16'(rv), 16'h00);

        // R5 modulo-16 wrap, R6 CRC error, R10 disabled
        wr(4'h9, 8'h00);
        wr(4'h2, 8'h0F);
        wr(4'h4, 8'd0);
        sec_pulse(4'hF);
        ser_pulse(M_SYNC); ser_pulse(M_HOK); ser_pulse(M_SYNC); ser_pulse(M_SEC);
        chk("R5 sector wrap", 16'(drv_sector), 16'h0);
        sec_pulse(4'h0);
        ser_pulse(M_SYNC); ser_pulse(M_HOK); ser_pulse(M_SYNC); ser_pulse(M_SEC | M_CRC);
        repeat (3) @(negedge clk);
        rd(4'h5, rv); chk("R6 crc flag", 16'(rv), 16'h08);
        chk("R10 no irq when disabled", 16'(irq), 16'h0);

        // R6 header error
        wr(4'h4, 8'd0);
        sec_pulse(4'h0);
        ser_pulse(M_SYNC); ser_pulse(M_HBAD);
        repeat (3) @(negedge clk);
        rd(4'h5, rv); chk("R6 address flag", 16'(rv), 16'h20);

        // R6 format error
        wr(4'h4, 8'd0);
        sec_pulse(4'h0);
        ser_pulse(M_FMT);
        repeat (3) @(negedge clk);
        rd(4'h5, rv); chk("R6 format flag", 16'(rv), 16'h10);

        // R8 fault abort
        wr(4'h4, 8'd0);
        @(negedge clk); drv_fault[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd(4'h5, rv); chk("R8 fault abort", 16'(rv), 16'h02);
        drv_fault[0] = 1'b0;

        // R11 write gate
        wr(4'h3, 8'h01);
        wr(4'h4, 8'd1);
        sec_pulse(4'h0); ser_pulse(M_SYNC); ser_pulse(M_HOK);
        chk("R11 gate enabled", 16'({dma_req, dma_rd, drv_wr_gate}), 16'h5);
        ser_pulse(M_DONE);
        wr(4'h0, 8'd1);
        wr(4'h4, 8'd1);
        sec_pulse(4'h0); ser_pulse(M_SYNC); ser_pulse(M_HOK);
        chk("R11 gate masked", 16'({dma_req, drv_wr_gate}), 16'h2);
        ser_pulse(M_DONE);
        repeat (2) @(negedge clk);

        // R10 forced finish
        wr(4'hA, 8'h00);
        wr(4'h8, 8'h00);
        repeat (2) @(negedge clk);
        chk("R10 forced irq", 16'(irq), 16'h1);
        rd(4'h4, rv); chk("R10 forced busy", 16'(rv), 16'h01);
        wr(4'hB, 8'h00);
        chk("R10 forced ack", 16'(irq), 16'h0);
        rd(4'h4, rv); chk("R10 forced idle", 16'(rv), 16'h00);

        finish_run();
    end

endmodule